// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Set

This block holds the interrupt-request state that other cores post to one core, together with a small mailbox that carries the message payload. A requester sets bits in a pending-status word through a write-only set port. The owning core masks that word with an enable word and clears the bits it has handled through a write-only clear port. A single level interrupt line goes to the core.

The interrupt line does not follow `status & enable` at all times. It is raised only when a write to the set port leaves an enabled bit pending. It is lowered only when a write to the clear port leaves the status word at zero while the enable word is nonzero. Writes to the enable word never move the line. Software that clears status while the enable word is zero therefore sees the line stay high.

All accesses are single 32-bit transfers. A request is accepted in the cycle it is presented, and its read data and error flag appear on the cycle after. Only the low byte of the address selects a register.

Top module: `ipi_core_regs`

## Requirements
- R1: Register selection uses only address bits [7:0]. Any higher address bits have no effect on which register is accessed.
- R2: After reset, the status word, the enable word, every mailbox word, the read data, the error flag and the interrupt line are all zero.
- R3: A write to offset 0x08 (set port) ORs the write data into the status word. A read of offset 0x08 returns zero.
- R4: A set-port write drives the interrupt high on the next cycle when `(status | data) & enable` is nonzero. Otherwise the line keeps its previous level.
- R5: A write to offset 0x0C (clear port) removes the written bits from the status word. The interrupt goes low on the next cycle only when the new status is zero and the enable word is nonzero. Otherwise the line keeps its level. A read of 0x0C returns zero.
- R6: Enable writes, mailbox accesses, reads and idle cycles leave the interrupt line unchanged.
- R7: Offset 0x04 is the enable word, which is readable and writable.
- R8: Offset 0x00 reads the status word. A write to 0x00 leaves status unchanged and raises the error flag for that access.
- R9: Mailbox word i (0 to MBOX_WORDS-1) lives at offsets 0x20+4i. Any offset from 0x20 up to the last word's offset selects word `(offset-0x20)>>2`, and that word is readable and writable.
- R10: An access to any other low-byte offset raises the error flag. A read of it returns zero, and a write to it changes no state.
- R11: Read data and the error flag are registered and are valid in the cycle after the request. A write returns zero read data. A cycle with no request returns zero data and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address; only bits [7:0] decode |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, one cycle after the request |
| busErr | output | 1 | Error flag for the previous cycle's access |
| irqOut | output | 1 | Level interrupt to the core |

## Verification
The bench builds the block with ADDR_W=12 and eight mailbox words. The 12-bit address gives the bench upper bits to randomize, so R1 is tested on every access rather than only at the default width. With eight words, the top of the mailbox range (0x3C) and the offsets just beyond it (0x3D to 0x40) can be reached. A reference model follows the set-raise and clear-lower rules across random mixes of enable, set and clear writes. This exposes the case where the line stays high after status is cleared with the enable word at zero.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;

  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;
  localparam logic [7:0] MBOX_BASE  = 8'h20;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2,
    RD_MBOX   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   enWr;
    logic   setWr;
    logic   clrWr;
    logic   mboxWr;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_regs_pkg::*;
#(
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [7:0]       offs,
  output strobe_t          strb,
  output logic [IDX_W-1:0] mboxIdx,
  output logic             errQ
);

  localparam logic [7:0] MBOX_LAST = 8'(32 + 4 * (MBOX_WORDS - 1));

  logic isMbox;
  logic errNext;

  assign isMbox = (offs >= MBOX_BASE) && (offs <= MBOX_LAST);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    errNext    = 1'b0;
    mboxIdx    = '0;
    if (isMbox) begin
      mboxIdx = IDX_W'((offs - MBOX_BASE) >> 2);
    end
    if (busValid) begin
      if (offs == OFF_STATUS) begin
        if (busWrite) errNext = 1'b1;
        else          strb.rdSel = RD_STATUS;
      end else if (offs == OFF_ENABLE) begin
        if (busWrite) strb.enWr = 1'b1;
        else          strb.rdSel = RD_ENABLE;
      end else if (offs == OFF_SET) begin
        strb.setWr = busWrite;
      end else if (offs == OFF_CLEAR) begin
        strb.clrWr = busWrite;
      end else if (isMbox) begin
        if (busWrite) strb.mboxWr = 1'b1;
        else          strb.rdSel = RD_MBOX;
      end else begin
        errNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= errNext;
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enWr, strb.setWr, strb.clrWr, strb.mboxWr})); // R10

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    errNext |-> !(strb.enWr || strb.setWr || strb.clrWr || strb.mboxWr)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !errQ); // R11

endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_regs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  mboxIdx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdataQ,
  output logic              irqQ
);

  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] enableQ;
  logic [DATA_W-1:0] mboxQ [MBOX_WORDS];
  logic [DATA_W-1:0] statusSet;
  logic [DATA_W-1:0] statusClr;
  logic [DATA_W-1:0] rdNext;

  assign statusSet = statusQ | wdata;
  assign statusClr = statusQ & ~wdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strb.enWr) enableQ <= wdata;
      if (strb.setWr) begin
        statusQ <= statusSet;
        if ((statusSet & enableQ) != '0) irqQ <= 1'b1;
      end
      if (strb.clrWr) begin
        statusQ <= statusClr;
        if (statusClr == '0 && enableQ != '0) irqQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < MBOX_WORDS; w++) mboxQ[w] <= '0;
    end else if (strb.mboxWr) begin
      for (int w = 0; w < MBOX_WORDS; w++) begin
        if (mboxIdx == IDX_W'(w)) mboxQ[w] <= wdata;
      end
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_STATUS: rdNext = statusQ;
      RD_ENABLE: rdNext = enableQ;
      RD_MBOX:   rdNext = mboxQ[mboxIdx];
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else       rdataQ <= rdNext;
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setWr && ((statusQ | wdata) & enableQ) != '0) |=> irqQ); // R4

  AST_CLEAR_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrWr && (statusQ & ~wdata) == '0 && enableQ != '0) |=> !irqQ); // R5

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setWr && !strb.clrWr) |=> $stable(irqQ)); // R6

  AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R3

  AST_WRITE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enWr || strb.setWr || strb.clrWr || strb.mboxWr) |=> rdataQ == '0); // R11

endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_regs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic              irqOut
);

  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;

  strobe_t          strb;
  logic [IDX_W-1:0] mboxIdx;

  ipi_ctrl #(
    .MBOX_WORDS(MBOX_WORDS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWrite(busWrite),
    .offs    (busAddr[7:0]),
    .strb    (strb),
    .mboxIdx (mboxIdx),
    .errQ    (busErr)
  );

  ipi_datapath #(
    .DATA_W    (DATA_W),
    .MBOX_WORDS(MBOX_WORDS)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .mboxIdx(mboxIdx),
    .wdata  (busWdata),
    .rdataQ (busRdata),
    .irqQ   (irqOut)
  );

endmodule

// File: tb/sim_ipi_core_regs.sv
module sim_ipi_core_regs;

  localparam int AW = 12;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mStatus, mEnable;
  logic        mIrq;
  logic [31:0] mMbox [NW];

  ipi_core_regs #(.ADDR_W(AW), .DATA_W(32), .MBOX_WORDS(NW)) u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .irqOut(irqOut)
  );

  initial forever #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isMb(input logic [7:0] o);
    return (o >= 8'h20) && (o <= 8'h3C);
  endfunction

  function automatic string tagOf(input bit we, input logic [7:0] o);
    if (o == 8'h00) return we ? "R8" : "R8_read";
    if (o == 8'h04) return "R7";
    if (o == 8'h08) return "R3";
    if (o == 8'h0C) return "R5";
    if (isMb(o))    return "R9";
    return "R10";
  endfunction

  task automatic access(input bit we, input logic [11:0] a, input logic [31:0] d);
    logic [7:0]  o = a[7:0];
    logic [31:0] expRd = '0;
    logic        expErr = 1'b0;
    logic [31:0] ns;
    string       tg = tagOf(we, o);
    if (!we) begin
      if (o == 8'h00)      expRd = mStatus;
      else if (o == 8'h04) expRd = mEnable;
      else if (o == 8'h08 || o == 8'h0C) expRd = '0;
      else if (isMb(o))    expRd = mMbox[(o - 8'h20) >> 2];
      else                 expErr = 1'b1;
    end else begin
      if (o == 8'h00) expErr = 1'b1;
      else if (o == 8'h04) mEnable = d;
      else if (o == 8'h08) begin
        ns = mStatus | d;
        if ((ns & mEnable) != 0) mIrq = 1'b1;
        mStatus = ns;
      end else if (o == 8'h0C) begin
        ns = mStatus & ~d;
        if (ns == 0 && mEnable != 0) mIrq = 1'b0;
        mStatus = ns;
      end else if (isMb(o)) mMbox[(o - 8'h20) >> 2] = d;
      else expErr = 1'b1;
    end
    @(negedge clk);
    busValid = 1'b1; busWrite = we; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    check({tg, " rdata R11"}, busRdata, expRd);
    check({tg, " err"}, {31'd0, busErr}, {31'd0, expErr});
    check({tg, " irq R4"}, {31'd0, irqOut}, {31'd0, mIrq});
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    mStatus = '0; mEnable = '0; mIrq = 1'b0;
    for (int i = 0; i < NW; i++) mMbox[i] = '0;
    repeat (3) @(negedge clk);
    check("R2 rdata", busRdata, 32'd0);
    check("R2 err", {31'd0, busErr}, 32'd0);
    check("R2 irq", {31'd0, irqOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    access(0, 12'h000, 0);
    access(0, 12'h004, 0);
    for (int i = 0; i < NW; i++) access(0, 12'(32 + 4 * i), 0);
    // R3 R4: set with nothing enabled leaves irq low, then enable does not raise it (R6)
    access(1, 12'h008, 32'h0000_0010);
    access(1, 12'h004, 32'h0000_0010);
    access(1, 12'h008, 32'h0000_0001);
    access(1, 12'h008, 32'h0000_0020);
    // R5 quirk: clear with enable zero keeps irq high
    access(1, 12'h004, 32'h0);
    access(1, 12'h00C, 32'hFFFF_FFFF);
    check("R5 quirk irq high", {31'd0, irqOut}, 32'd1);
    access(1, 12'h004, 32'h0000_0002);
    access(1, 12'h00C, 32'h0);
    check("R5 lowered", {31'd0, irqOut}, 32'd0);
    // R5: partial clear keeps irq
    access(1, 12'h008, 32'h0000_0006);
    access(1, 12'h00C, 32'h0000_0002);
    check("R5 partial keeps", {31'd0, irqOut}, 32'd1);
    // R8 status write ignored; R1 upper bits
    access(1, 12'h700, 32'hFFFF_FFFF);
    access(0, 12'hA00, 0);
    access(1, 12'hF04, 32'h1234_5678);
    access(0, 12'h304, 0);
    // R9 R10 boundaries
    access(1, 12'h03C, 32'hCAFE_0007);
    access(0, 12'h03C, 0);
    access(1, 12'h03D, 32'hDEAD_BEEF);
    access(1, 12'h040, 32'hDEAD_BEEF);
    access(0, 12'h040, 0);
    access(0, 12'h01F, 0);
    access(0, 12'h001, 0);
    // R11 idle cycle returns zero
    @(negedge clk);
    check("R11 idle rdata", busRdata, 32'd0);
    check("R11 idle err", {31'd0, busErr}, 32'd0);
    for (int n = 0; n < 1500; n++) begin
      logic [11:0] a = 12'($urandom);
      logic [31:0] d = $urandom;
      int pick = $urandom % 10;
      case (pick)
        0: a[7:0] = 8'h00;
        1: a[7:0] = 8'h04;
        2, 3: a[7:0] = 8'h08;
        4, 5: a[7:0] = 8'h0C;
        6, 7: a[7:0] = 8'(32 + 4 * ($urandom % NW));
        default: ;
      endcase
      if (pick == 4 && ($urandom % 2) == 1) d = mStatus;
      if (pick == 1 && ($urandom % 3) == 0) d = '0;
      if ((pick == 2 || pick == 3) && ($urandom % 2) == 1) d = 32'(1) << ($urandom % 32);
      access($urandom % 2, a, d);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule